// File: doc/BRIEF.md
# Pausable Fibonacci Term Generator

This block is a free-running source of Fibonacci terms. It keeps a pair of fixed-width words (a current term and the next term). On every rising clock edge it either steps the pair forward by one position in the sequence or keeps it exactly as it is. The current term is driven onto the output at all times.

A single `pause` bit chooses between the two actions on each edge. While `pause` is high the whole pair is frozen, not only the output. When `pause` drops, the sequence resumes from the term it stopped on, and no term is skipped. The adder wraps at the word width, so the sequence keeps running past the largest value the word can hold.

There is no valid/ready handshake at this edge. The output is valid on every cycle. The only flow control is the `pause` bit, which acts on the next edge.

Top module: `fib_seq_gen`

## Requirements
- R1: The output `term` always equals the current-term word of the internal pair, and it is driven straight from a register.
- R2: `rst` is synchronous and active high. On an edge where it is high, the pair becomes current = 0 and next = 1, whatever the value of `pause`. The output reads 0x00 after that edge.
- R3: On an edge where `rst` is low and `pause` is low, the pair (current, next) becomes (next, current + next).
- R4: On an edge where `rst` is low and `pause` is high, both words of the pair keep their values, so the output repeats its previous term.
- R5: The sum is taken modulo 2^WORD_W (256 by default) with no carry out. After the wrap the sequence continues: the fourteenth term after reset reads 0x79.
- R6: `pause` has no combinational path to `term`. Changing `pause` between edges leaves `term` unchanged until the next edge.
- R7: With `pause` held low after reset, the outputs after successive edges read 0x01, 0x01, 0x02, 0x03, 0x05, 0x08, 0x0D, 0x15, 0x22, 0x37.
- R8: After reset, the `pause` pattern low, high, low, low, low gives the outputs 0x01, 0x01, 0x01, 0x02, 0x03 after those five edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pause | input | 1 | High: freeze the pair on the next edge |
| term | output | WORD_W (8) | Current Fibonacci term |

## Verification
The bench targets the following faults:

- **Pause that only gates the output.** A design that lets the next-term word run on while paused would resume with a skipped term. The one-cycle pause trace and the long random pause runs catch this.
- **Carry that leaks past the word width.** A wider or saturating adder would break the sequence at the wrap from 0xE9 to 0x79.
- **Reset that obeys `pause`.** A reset that honours `pause`, or a pair that starts at (1, 1), would shift the whole trace by one term.
- **Combinational path from `pause`.** Toggling `pause` in mid-cycle exposes any path from `pause` to `term`.

// File: rtl/fib_pkg.sv
package fib_pkg;
  localparam int WORD_W = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t cur;
    word_t nxt;
  } pair_t;

  localparam word_t SEED_CUR = word_t'(0);
  localparam word_t SEED_NXT = word_t'(1);
endpackage

// File: rtl/fib_wrap_add.sv
module fib_wrap_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
  end
  // carry[W] is dropped on purpose: the sum wraps modulo 2^W
  logic unused_carry;
  assign unused_carry = carry[W];
endmodule

// File: rtl/fib_pair_reg.sv
module fib_pair_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED_CUR = '0,
  parameter logic [W-1:0] SEED_NXT = W'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] step_cur,
  input  logic [W-1:0] step_nxt,
  output logic [W-1:0] cur_q,
  output logic [W-1:0] nxt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= SEED_CUR;
      nxt_q <= SEED_NXT;
    end else if (!hold) begin
      cur_q <= step_cur;
      nxt_q <= step_nxt;
    end
  end

  AST_SEED_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (cur_q == SEED_CUR && nxt_q == SEED_NXT)); // R2

  AST_HOLD_FREEZES_PAIR: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(cur_q) && $stable(nxt_q))); // R4

  AST_ADVANCE_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (cur_q == $past(nxt_q))); // R3

  AST_ADVANCE_WRAPS: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (nxt_q == W'($past(cur_q) + $past(nxt_q)))); // R5
endmodule

// File: rtl/fib_seq_gen.sv
module fib_seq_gen
  import fib_pkg::*;
#(
  parameter int WORD_W_P = fib_pkg::WORD_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pause,
  output logic [WORD_W_P-1:0] term
);
  localparam logic [WORD_W_P-1:0] SEED_C = WORD_W_P'(0);
  localparam logic [WORD_W_P-1:0] SEED_N = WORD_W_P'(1);

  logic [WORD_W_P-1:0] cur_w;
  logic [WORD_W_P-1:0] nxt_w;
  logic [WORD_W_P-1:0] sum_w;

  fib_wrap_add #(.W(WORD_W_P)) u_add (
    .a   (cur_w),
    .b   (nxt_w),
    .sum (sum_w)
  );

  fib_pair_reg #(
    .W        (WORD_W_P),
    .SEED_CUR (SEED_C),
    .SEED_NXT (SEED_N)
  ) u_pair (
    .clk      (clk),
    .rst      (rst),
    .hold     (pause),
    .step_cur (nxt_w),
    .step_nxt (sum_w),
    .cur_q    (cur_w),
    .nxt_q    (nxt_w)
  );

  assign term = cur_w;

  AST_TERM_STABLE_BETWEEN_EDGES: assert property (@(posedge clk) disable iff (rst)
    pause |=> $stable(term)); // R6
endmodule

// File: tb/fib_seq_gen_bench.sv
module fib_seq_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pause = 1'b0;
  logic [7:0] term;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fib_seq_gen u_fib_seq_gen (
    .clk   (clk),
    .rst   (rst),
    .pause (pause),
    .term  (term)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // drive on the falling edge, sample 2 ns after the rising edge
  task automatic step(input logic r, input logic p);
    @(negedge clk);
    rst = r;
    pause = p;
    @(posedge clk);
    #2;
  endtask

  // entry fields: {rst, pause, expected term}
  localparam int NV = 22;
  localparam logic [9:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h01}, {1'b0, 1'b0, 8'h01}, {1'b0, 1'b0, 8'h02},
    {1'b0, 1'b0, 8'h03}, {1'b0, 1'b0, 8'h05}, {1'b0, 1'b0, 8'h08},
    {1'b0, 1'b0, 8'h0D}, {1'b0, 1'b0, 8'h15}, {1'b0, 1'b0, 8'h22},
    {1'b0, 1'b0, 8'h37}, {1'b0, 1'b0, 8'h59}, {1'b0, 1'b0, 8'h90},
    {1'b0, 1'b0, 8'hE9}, {1'b0, 1'b0, 8'h79},
    {1'b1, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h01}, {1'b0, 1'b1, 8'h01}, {1'b0, 1'b0, 8'h01},
    {1'b0, 1'b0, 8'h02}, {1'b0, 1'b0, 8'h03},
    {1'b1, 1'b0, 8'h00}
  };

  logic [7:0] rc, rn, rs;
  bit done = 1'b0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // table walk: R2 reset, R7 trace, R5 wrap at entry 14, R2 reset with pause high, R8 pause trace
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9], VEC[i][8]);
      check($sformatf("R1 R2 R3 R4 R5 R7 R8 vec%0d", i), term, VEC[i][7:0]);
    end

    // R6: toggle pause in mid-cycle, term must not move before the edge
    step(1'b0, 1'b0);
    rc = term;
    #1 pause = 1'b1;
    #1 check("R6 pause rise mid-cycle", term, rc);
    pause = 1'b0;
    #1 check("R6 pause fall mid-cycle", term, rc);

    // random pause runs against a reference pair, covering many wraps (R3 R4 R5)
    step(1'b1, 1'b0);
    rc = 8'h00;
    rn = 8'h01;
    check("R2 reset before random run", term, rc);
    begin
      logic p = 1'b0;
      for (int k = 0; k < 400; k++) begin
        int len = (k % 50 == 0) ? 20 : 1;
        if (($urandom % 4) == 0) p = ~p;
        for (int j = 0; j < len; j++) begin
          step(1'b0, p);
          if (!p) begin
            rs = rc + rn;
            rc = rn;
            rn = rs;
          end
          check(p ? "R4 hold random" : "R3 R5 advance random", term, rc);
        end
      end
    end

    // R2: reset while pause is high in mid-run
    step(1'b1, 1'b1);
    check("R2 reset mid-run with pause", term, 8'h00);
    step(1'b0, 1'b1);
    check("R4 hold right after reset", term, 8'h00);
    step(1'b0, 1'b0);
    check("R3 first advance after held reset", term, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule